// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in memory. A requester supplies the virtual address, an access type (read, write or execute) and the base address of the page directory. It then pulses `start`. The walker reads the directory entry, follows it to a second-level table, reads the leaf entry and checks the valid and permission bits against the access type. It finishes with a one-cycle `done` pulse carrying either the physical address or a fault code.

Memory is reached through a simple word port. A one-cycle request goes out, and the walker waits any number of cycles for a one-cycle acknowledge. A successful write through a leaf entry whose dirty bit is still clear causes a write-back. The walker writes the entry back with the dirty bit set, then reports completion. Recovering from a fault is left to the requester; the block only classifies the fault.

Top module: `page_walker`

## Requirements
- R1: After synchronous reset, `done`, `mem_req` and `mem_we` are 0, and `fault` and `paddr` are 0.
- R2: The first memory access of a walk is a read (`mem_we`=0) at `ptbr + 4*vaddr[31:22]`.
- R3: When the directory entry is valid, the second access is a read at `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: On success, `paddr` = `{leaf[31:12], vaddr[11:0]}` and `fault` = 2'b00.
- R5: A directory entry with bit 0 (valid) clear gives `fault` = 2'b01. The walk makes exactly one read and no write.
- R6: A leaf entry with bit 0 clear gives `fault` = 2'b01, whatever its other bits hold.
- R7: Access code 2'b00 (read) needs bit 1, 2'b01 (write) needs bit 2, and 2'b10 (execute) needs bit 3 of a valid leaf. Code 2'b11 is never permitted. A missing permission gives `fault` = 2'b10.
- R8: A permitted write whose leaf has bit 4 (dirty) clear writes the leaf back to the same address with bit 4 set, before `done`. No other walk issues a write.
- R9: `done` is a one-cycle pulse. On any fault `paddr` is 0. `fault` and `paddr` hold until the next walk completes.
- R10: `start` has no effect while a walk is in progress.
- R11: Each request is a one-cycle `mem_req` pulse. The walker waits for `mem_ack` for any number of cycles before moving on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| vaddr | input | 32 | Virtual address to translate |
| access | input | 2 | 00 read, 01 write, 10 execute, 11 reserved |
| ptbr | input | 32 | Page directory base address |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 00 none, 01 page fault, 10 permission fault |
| paddr | output | 32 | Translated physical address |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory response strobe |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Invalid directory entries are targeted. A walker that still read the leaf would show a second read and might report the wrong fault. Leaves that are invalid but carry every permission bit check the order of the tests. A design that tested permissions before validity would report 2'b10 or translate the address. Writes to clean and to already-dirty pages are mixed with read and execute accesses. This catches a missing write-back, a write-back with the wrong data, and a spurious write on a non-write access. Random memory latency, the reserved access code, index values 0 and 1023, and a `start` pulse in the middle of a walk round out the cases.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int VA_W        = 32;
    localparam int OFF_W       = 12;
    localparam int IDX_W       = 10;
    localparam int LEVELS      = 2;
    localparam int ENTRY_W     = 32;
    localparam int PPN_W       = VA_W - OFF_W;
    localparam int FLAG_W      = 5;
    localparam int RSVD_W      = ENTRY_W - PPN_W - FLAG_W;
    localparam int DIR_LSB     = OFF_W + IDX_W;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PERM = 2'b10
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WT_DIR,
        ST_RD_LEAF,
        ST_WT_LEAF,
        ST_WR_LEAF,
        ST_WT_WR,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [RSVD_W-1:0] rsvd;
        logic              d;
        logic              x;
        logic              w;
        logic              r;
        logic              v;
    } pte_t;

    function automatic logic perm_ok(input pte_t e, input acc_e a);
        case (a)
            ACC_READ:  return e.r;
            ACC_WRITE: return e.w;
            ACC_EXEC:  return e.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr
    import pw_pkg::*;
#(
    parameter int AW  = VA_W,
    parameter int IW  = IDX_W,
    parameter int SHF = ENTRY_SHIFT
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam int PAD = AW - IW;

    always_comb begin
        addr = base + ({{PAD{1'b0}}, idx} << SHF);
    end
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
    import pw_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  acc_e               acc,
    input  logic               leaf,
    output fault_e             flt,
    output logic               need_dirty
);
    pte_t e;
    logic allowed;
    logic unused_rsvd;

    assign e           = pte_t'(entry);
    assign unused_rsvd = ^e.rsvd;

    always_comb begin
        allowed    = perm_ok(e, acc);
        flt        = FLT_NONE;
        need_dirty = 1'b0;
        if (!e.v) begin
            flt = FLT_PAGE;
        end else if (leaf) begin
            if (!allowed) begin
                flt = FLT_PERM;
            end else begin
                need_dirty = (acc == ACC_WRITE) && !e.d;
            end
        end
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] vaddr,
    input  logic [1:0]  access,
    input  logic [31:0] ptbr,
    output logic        done,
    output logic [1:0]  fault,
    output logic [31:0] paddr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    walk_st_e          state;
    logic [VA_W-1:0]   va_q;
    logic [VA_W-1:0]   ptbr_q;
    logic [VA_W-1:0]   tbl_base_q;
    acc_e              acc_q;
    pte_t              leaf_q;
    fault_e            fault_q;
    logic [VA_W-1:0]   paddr_q;

    logic [VA_W-1:0]   lvl_base [LEVELS];
    logic [IDX_W-1:0]  lvl_idx  [LEVELS];
    logic [VA_W-1:0]   lvl_addr [LEVELS];

    fault_e            chk_flt;
    logic              chk_dirty;
    pte_t              rd_entry;

    assign lvl_base[0] = ptbr_q;
    assign lvl_idx[0]  = va_q[DIR_LSB +: IDX_W];
    assign lvl_base[1] = tbl_base_q;
    assign lvl_idx[1]  = va_q[OFF_W +: IDX_W];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
            pw_entry_addr #(.AW(VA_W), .IW(IDX_W), .SHF(ENTRY_SHIFT)) u_addr (
                .base (lvl_base[g]),
                .idx  (lvl_idx[g]),
                .addr (lvl_addr[g])
            );
        end
    endgenerate

    pw_entry_check u_check (
        .entry      (mem_rdata),
        .acc        (acc_q),
        .leaf       (state == ST_WT_LEAF),
        .flt        (chk_flt),
        .need_dirty (chk_dirty)
    );

    assign rd_entry = pte_t'(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            va_q       <= '0;
            ptbr_q     <= '0;
            tbl_base_q <= '0;
            acc_q      <= ACC_READ;
            leaf_q     <= '0;
            fault_q    <= FLT_NONE;
            paddr_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        va_q   <= vaddr;
                        ptbr_q <= ptbr;
                        acc_q  <= acc_e'(access);
                        state  <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR:  state <= ST_WT_DIR;
                ST_WT_DIR: begin
                    if (mem_ack) begin
                        if (chk_flt != FLT_NONE) begin
                            fault_q <= chk_flt;
                            paddr_q <= '0;
                            state   <= ST_DONE;
                        end else begin
                            tbl_base_q <= {rd_entry.ppn, {OFF_W{1'b0}}};
                            state      <= ST_RD_LEAF;
                        end
                    end
                end
                ST_RD_LEAF: state <= ST_WT_LEAF;
                ST_WT_LEAF: begin
                    if (mem_ack) begin
                        leaf_q <= rd_entry;
                        if (chk_flt != FLT_NONE) begin
                            fault_q <= chk_flt;
                            paddr_q <= '0;
                            state   <= ST_DONE;
                        end else if (chk_dirty) begin
                            state <= ST_WR_LEAF;
                        end else begin
                            fault_q <= FLT_NONE;
                            paddr_q <= {rd_entry.ppn, va_q[OFF_W-1:0]};
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_WR_LEAF: state <= ST_WT_WR;
                ST_WT_WR: begin
                    if (mem_ack) begin
                        fault_q <= FLT_NONE;
                        paddr_q <= {leaf_q.ppn, va_q[OFF_W-1:0]};
                        state   <= ST_DONE;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[0];
            end
            ST_RD_LEAF: begin
                mem_req  = 1'b1;
                mem_addr = lvl_addr[1];
            end
            ST_WR_LEAF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lvl_addr[1];
                mem_wdata = {leaf_q[ENTRY_W-1:FLAG_W], 1'b1, leaf_q[FLAG_W-2:0]};
            end
            default: ;
        endcase
    end

    assign done  = (state == ST_DONE);
    assign fault = fault_q;
    assign paddr = paddr_q;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'b00) |-> paddr == '0); // R9
    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[4] && mem_wdata[2] && mem_wdata[0])); // R8
    AST_LEAF_AFTER_DIR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_LEAF) |-> $past(state) == ST_WT_DIR); // R3
    AST_QUIET_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R11
endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] vaddr;
    logic [1:0]  access;
    logic [31:0] ptbr;
    logic        done;
    logic [1:0]  fault;
    logic [31:0] paddr;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #2 clk = ~clk;

    page_walker dut (
        .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .access(access),
        .ptbr(ptbr), .done(done), .fault(fault), .paddr(paddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [logic [31:0]];
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    int          rd_cnt, wr_cnt;
    logic [31:0] rd_log [4];
    logic [31:0] wr_addr, wr_data;
    logic        pend;
    int          lat;
    logic [31:0] p_addr;

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        cyc <= cyc + 1;
        if (rst) begin
            pend <= 1'b0;
        end else if (mem_req) begin
            pend   <= 1'b1;
            lat    <= int'($urandom % 4);
            p_addr <= mem_addr;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_addr = mem_addr;
                wr_data = mem_wdata;
                wr_cnt++;
            end else begin
                if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
            end
        end else if (pend) begin
            if (lat == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd_mem(p_addr);
                pend      <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit perm(input logic [31:0] e, input logic [1:0] a);
        case (a)
            2'b00:   return e[1];
            2'b01:   return e[2];
            2'b10:   return e[3];
            default: return 1'b0;
        endcase
    endfunction

    task automatic walk(input logic [31:0] pt, input logic [31:0] va,
                        input logic [1:0] acc, input bit poke, input string tag);
        logic [31:0] pde_a, pde, pte_a, pte, e_pa;
        logic [1:0]  e_f;
        int          e_rd, e_wr, w;
        pde_a = pt + {20'h0, va[31:22], 2'b00};
        pde   = rd_mem(pde_a);
        pte_a = {pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        pte   = rd_mem(pte_a);
        e_wr = 0; e_pa = 0;
        if (!pde[0]) begin
            e_f = 2'b01; e_rd = 1;
        end else begin
            e_rd = 2;
            if (!pte[0])             e_f = 2'b01;
            else if (!perm(pte, acc)) e_f = 2'b10;
            else begin
                e_f  = 2'b00;
                e_pa = {pte[31:12], va[11:0]};
                if (acc == 2'b01 && !pte[4]) e_wr = 1;
            end
        end
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        start = 1'b1; vaddr = va; access = acc; ptbr = pt;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; vaddr = ~va; access = ~acc; ptbr = pt + 32'h40;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 200) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, "R11", {tag, " done seen"}, 32'(done), 32'h1);
        chk(fault == e_f, (e_f == 2'b10) ? "R7" : (e_f == 2'b01 ? "R5/R6" : "R4"),
            {tag, " fault"}, 32'(fault), 32'(e_f));
        chk(paddr == e_pa, (e_f == 2'b00) ? "R4" : "R9", {tag, " paddr"}, paddr, e_pa);
        chk(rd_cnt == e_rd, "R5", {tag, " reads"}, 32'(rd_cnt), 32'(e_rd));
        chk(rd_log[0] == pde_a, "R2", {tag, " dir addr"}, rd_log[0], pde_a);
        if (e_rd == 2 && rd_cnt >= 2)
            chk(rd_log[1] == pte_a, "R3", {tag, " leaf addr"}, rd_log[1], pte_a);
        chk(wr_cnt == e_wr, "R8", {tag, " writes"}, 32'(wr_cnt), 32'(e_wr));
        if (e_wr == 1 && wr_cnt == 1) begin
            chk(wr_addr == pte_a, "R8", {tag, " wb addr"}, wr_addr, pte_a);
            chk(wr_data == (pte | 32'h10), "R8", {tag, " wb data"}, wr_data, pte | 32'h10);
        end
        if (poke)
            chk(rd_cnt == e_rd && fault == e_f, "R10", {tag, " busy start"}, 32'(rd_cnt), 32'(e_rd));
        @(negedge clk);
        chk(done == 1'b0, "R9", {tag, " done pulse"}, 32'(done), 32'h0);
        chk(fault == e_f && paddr == e_pa, "R9", {tag, " hold"}, paddr, e_pa);
    endtask

    task automatic setup(input logic [31:0] pt, input logic [31:0] va,
                         input logic [31:0] pde, input logic [31:0] pte);
        mem[pt + {20'h0, va[31:22], 2'b00}] = pde;
        mem[{pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00}] = pte;
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 32'(cyc), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] pt, va, pde, pte;
        void'($urandom(32'd7331));
        rst = 1'b1; start = 1'b0; vaddr = 0; access = 0; ptbr = 0;
        mem_rdata = 0; mem_ack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !mem_req && !mem_we, "R1", "reset controls", {29'h0, done, mem_req, mem_we}, 32'h0);
        chk(fault == 2'b00 && paddr == 32'h0, "R1", "reset outputs", paddr, 32'h0);

        pt = 32'h0010_0000;
        // R4: plain read
        setup(pt, 32'h0040_3ABC, 32'h0020_0001, 32'h4123_B003);
        walk(pt, 32'h0040_3ABC, 2'b00, 0, "R4 read");
        // R8: write to clean page, then same page now dirty
        setup(pt, 32'h0080_5123, 32'h0020_1001, 32'h1004_5007);
        walk(pt, 32'h0080_5123, 2'b01, 0, "R8 clean write");
        walk(pt, 32'h0080_5123, 2'b01, 0, "R8 dirty write");
        // R7: execute without X, reserved code
        setup(pt, 32'h00C0_7FFF, 32'h0020_2001, 32'hC20A_3007);
        walk(pt, 32'h00C0_7FFF, 2'b10, 0, "R7 exec");
        walk(pt, 32'h00C0_7FFF, 2'b11, 0, "R7 reserved");
        // R5: invalid directory entry
        setup(pt, 32'h0100_0000, 32'h0020_3000, 32'h0000_F00F);
        walk(pt, 32'h0100_0000, 2'b00, 0, "R5 dir invalid");
        // R6: invalid leaf with every permission
        setup(pt, 32'h0140_0000, 32'h0020_4001, 32'h5555_501E);
        walk(pt, 32'h0140_0000, 2'b10, 0, "R6 leaf invalid");
        // R2/R3 index boundaries
        setup(pt, 32'hFFFF_FFFF, 32'h0020_5001, 32'hABCD_E00F);
        walk(pt, 32'hFFFF_FFFF, 2'b10, 0, "R2 top idx");
        setup(pt, 32'h0000_0000, 32'h0020_6001, 32'h0001_2003);
        walk(pt, 32'h0000_0000, 2'b00, 0, "R3 zero idx");
        // R10: start while busy
        walk(pt, 32'h0040_3ABC, 2'b00, 1, "R10 busy");

        for (int i = 0; i < 300; i++) begin
            va  = $urandom;
            pde = {12'h0, 8'h20 + 8'($urandom % 200), 11'h0, 1'b1};
            if ($urandom % 8 == 0) pde[0] = 1'b0;
            pte = {$urandom % 32'hFFFFF + 32'h1, 7'h0, 5'($urandom)} ;
            pte = {pte[19:0], 7'h0, pte[4:0]};
            setup(pt, va, pde, pte);
            walk(pt, va, 2'($urandom), (i % 25) == 3, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule